// File: doc/BRIEF.md
# Dual-Mode SD Card Clock Divider

This block derives the SD card clock from the core clock. A divider setting of eleven bits holds the wanted division ratio minus two, so the card clock runs at the core rate divided by (setting + 2). There are two ways to read the setting. In identification operation all eleven bits count. In data operation only the three lowest bits count, which limits the ratio to the range 2 to 9. A slow-card control forces the full eleven-bit reading in both operations. That is needed when the core clock is too fast for the short data-mode ratio.

The clock cannot be stopped. The slowest rate comes from the all-ones setting (0x7FF), which divides by 2049. The block samples its inputs only at the start of each output period. A new ratio or mode therefore never cuts a period short. The output is a registered level, `sdClk`. Two single-cycle strobes, `riseEn` and `fallEn`, mark the cycles in which that level has just gone high or low, so logic downstream can use them as clock enables. The high phase takes the larger half of an odd ratio. After reset, the first period uses a built-in setting of 507, whatever the inputs are.

Top module: `sd_clk_divider`

## Requirements
- R1: With `dataMode`=0 and `slowCard`=0, every output period lasts N = `divVal` + 2 core cycles, where `divVal` is read as an unsigned 11-bit number.
- R2: With `dataMode`=1 and `slowCard`=0, only `divVal[2:0]` is used, N = `divVal[2:0]` + 2, and `divVal[10:3]` has no effect on the period.
- R3: With `slowCard`=1, N = `divVal` + 2 using all 11 bits, whatever the value of `dataMode`.
- R4: Each period begins with a high phase of N - floor(N/2) cycles and ends with a low phase of floor(N/2) cycles.
- R5: `divVal`, `dataMode` and `slowCard` are sampled only on the clock edge that starts a period. A change made during a period leaves that period's high and low lengths unchanged and applies from the next period.
- R6: While `rstN` is low, `sdClk`=1, `riseEn`=0 and `fallEn`=0. The period that begins when reset is released uses a setting of 507 (N=509: 255 high cycles, then 254 low cycles), whatever the inputs are.
- R7: `riseEn` is 1 in exactly the cycles where `sdClk` is 1 and was 0 in the previous cycle. `fallEn` is 1 in exactly the cycles where `sdClk` is 0 and was 1 in the previous cycle.
- R8: The setting 0x7FF gives the slowest clock, N=2049 (1025 high, 1024 low). The output keeps toggling at every setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divVal | input | 11 | Divider setting, ratio minus two |
| slowCard | input | 1 | Forces the full 11-bit setting in every mode |
| dataMode | input | 1 | 1 selects data operation (3-bit setting) |
| sdClk | output | 1 | Divided card clock level |
| riseEn | output | 1 | One-cycle pulse in the first high cycle of a period |
| fallEn | output | 1 | One-cycle pulse in the first low cycle of a period |

## Verification
The identification path is tried with settings 0, 1, 3, 7, 100 and 0x7FF. These cover the smallest ratio, odd and even ratios, and the widest counter value, so an error in the plus-two offset or in the odd-ratio duty split would show. Data operation is tried with settings whose upper bits are set and whose lowest three bits are 3, 7 and 0. These values tell field masking apart from use of the full value. The slow-card control is then set in both modes to show that it overrides the masking. A change of setting and mode in the middle of a period, and the built-in period after reset, show that inputs are sampled only at period boundaries.

// File: rtl/sd_clk_pkg.sv
package sd_clk_pkg;

  // Strobes passed from the control to the datapath once per core cycle.
  typedef struct packed {
    logic wrap;   // last cycle of the period: restart and load a new ratio
    logic fall;   // next cycle starts the low phase
  } div_strobe_t;

endpackage

// File: rtl/sd_clk_div_sel.sv
module sd_clk_div_sel #(
  parameter int DIV_W  = 11,
  parameter int DATA_W = 3,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divVal,
  input  logic             slowCard,
  input  logic             dataMode,
  output logic [CNT_W-1:0] selN,
  output logic [CNT_W-1:0] selHi
);

  localparam int DATA_MAX_N = (1 << DATA_W) + 1;

  logic [DIV_W-1:0] narrowVal;
  logic [DIV_W-1:0] rawVal;
  logic             useNarrow;

  // The short data-mode field exists only when it is narrower than the full field.
  generate
    if (DATA_W < DIV_W) begin : g_narrow
      assign narrowVal = {{(DIV_W-DATA_W){1'b0}}, divVal[DATA_W-1:0]};
    end else begin : g_full
      assign narrowVal = divVal;
    end
  endgenerate

  assign useNarrow = dataMode && !slowCard;

  always_comb begin
    rawVal = useNarrow ? narrowVal : divVal;
    selN   = {1'b0, rawVal} + CNT_W'(2);
    selHi  = selN - (selN >> 1);
  end

  AST_DATA_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    useNarrow |-> (selN <= CNT_W'(DATA_MAX_N)));  // R2

  AST_SLOW_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (slowCard && divVal[DIV_W-1]) |-> (selN > CNT_W'(DATA_MAX_N)));  // R3

endmodule

// File: rtl/sd_clk_div_ctrl.sv
module sd_clk_div_ctrl
  import sd_clk_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] curN,
  input  logic [CNT_W-1:0] curHi,
  output div_strobe_t      stb
);

  always_comb begin
    stb.wrap = (cnt == curN - CNT_W'(1));
    stb.fall = ((cnt + CNT_W'(1)) == curHi);
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrap, stb.fall}));  // R4

endmodule

// File: rtl/sd_clk_div_path.sv
module sd_clk_div_path
  import sd_clk_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int RESET_N = 509,
  localparam int RESET_HI = RESET_N - RESET_N / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  div_strobe_t      stb,
  input  logic [CNT_W-1:0] selN,
  input  logic [CNT_W-1:0] selHi,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] curN,
  output logic [CNT_W-1:0] curHi,
  output logic             sdClkQ,
  output logic             riseQ,
  output logic             fallQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      curN   <= CNT_W'(RESET_N);
      curHi  <= CNT_W'(RESET_HI);
      sdClkQ <= 1'b1;
      riseQ  <= 1'b0;
      fallQ  <= 1'b0;
    end else if (stb.wrap) begin
      cnt    <= '0;
      curN   <= selN;
      curHi  <= selHi;
      sdClkQ <= 1'b1;
      riseQ  <= 1'b1;
      fallQ  <= 1'b0;
    end else begin
      cnt    <= cnt + CNT_W'(1);
      riseQ  <= 1'b0;
      fallQ  <= stb.fall;
      if (stb.fall) sdClkQ <= 1'b0;
    end
  end

  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    riseQ |-> (sdClkQ && !$past(sdClkQ)));  // R7

  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    fallQ |-> (!sdClkQ && $past(sdClkQ)));  // R7

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt < curN);  // R1

  AST_HOLD_RATIO: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |-> ($stable(curN) && $stable(curHi)));  // R5

  AST_MIN_RATIO: assert property (@(posedge clk) disable iff (!rstN)
    curN >= CNT_W'(2));  // R8

endmodule

// File: rtl/sd_clk_divider.sv
module sd_clk_divider
  import sd_clk_pkg::*;
#(
  parameter int DIV_W     = 11,
  parameter int DATA_W    = 3,
  parameter int RESET_DIV = 507
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divVal,
  input  logic             slowCard,
  input  logic             dataMode,
  output logic             sdClk,
  output logic             riseEn,
  output logic             fallEn
);

  localparam int CNT_W   = DIV_W + 1;
  localparam int RESET_N = RESET_DIV + 2;

  logic [CNT_W-1:0] selN;
  logic [CNT_W-1:0] selHi;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curN;
  logic [CNT_W-1:0] curHi;
  div_strobe_t      stb;

  sd_clk_div_sel #(.DIV_W(DIV_W), .DATA_W(DATA_W)) uSel (
    .clk(clk), .rstN(rstN), .divVal(divVal), .slowCard(slowCard),
    .dataMode(dataMode), .selN(selN), .selHi(selHi)
  );

  sd_clk_div_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cnt(cnt), .curN(curN), .curHi(curHi), .stb(stb)
  );

  sd_clk_div_path #(.CNT_W(CNT_W), .RESET_N(RESET_N)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .selN(selN), .selHi(selHi),
    .cnt(cnt), .curN(curN), .curHi(curHi),
    .sdClkQ(sdClk), .riseQ(riseEn), .fallQ(fallEn)
  );

endmodule

// File: tb/sd_clk_divider_test.sv
module sd_clk_divider_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] divVal = '0;
  logic        slowCard = 1'b0;
  logic        dataMode = 1'b0;
  logic        sdClk, riseEn, fallEn;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit monOn = 1'b0;
  logic prevClk = 1'b0;
  int edgeBad = 0;

  always #5 clk = ~clk;

  sd_clk_divider uut (
    .clk(clk), .rstN(rstN), .divVal(divVal), .slowCard(slowCard),
    .dataMode(dataMode), .sdClk(sdClk), .riseEn(riseEn), .fallEn(fallEn)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // R7 edge-strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (monOn) begin
      if (riseEn !== (sdClk && !prevClk)) edgeBad++;
      if (fallEn !== (!sdClk && prevClk)) edgeBad++;
    end
    prevClk = sdClk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expN(input int d, input bit dm, input bit sc);
    if (dm && !sc) return (d & 7) + 2;
    return d + 2;
  endfunction

  task automatic syncRise();
    do @(negedge clk); while (riseEn !== 1'b1);
  endtask

  task automatic measureFrom(output int hi, output int lo);
    hi = 0; lo = 0;
    while (sdClk === 1'b1) begin hi++; @(negedge clk); end
    while (sdClk === 1'b0) begin lo++; @(negedge clk); end
  endtask

  task automatic checkPeriod(input string tag, input int n);
    int hi, lo;
    syncRise();
    measureFrom(hi, lo);
    chk(hi == n - n / 2, {tag, " high"}, hi, n - n / 2);
    chk(lo == n / 2, {tag, " low"}, lo, n / 2);
  endtask

  task automatic applyAndCheck(input string tag, input int d, input bit dm, input bit sc);
    divVal = 11'(d); dataMode = dm; slowCard = sc;
    checkPeriod(tag, expN(d, dm, sc));
  endtask

  task automatic t_reset();
    int hi, lo;
    divVal = 11'd0; dataMode = 1'b0; slowCard = 1'b0;
    repeat (3) @(negedge clk);
    chk(sdClk === 1'b1, "R6 reset sdClk", int'(sdClk), 1);
    chk(riseEn === 1'b0, "R6 reset riseEn", int'(riseEn), 0);
    chk(fallEn === 1'b0, "R6 reset fallEn", int'(fallEn), 0);
    rstN = 1'b1;
    measureFrom(hi, lo);
    chk(hi == 255, "R6 first period high", hi, 255);
    chk(lo == 254, "R6 first period low", lo, 254);
    monOn = 1'b1;
  endtask

  task automatic t_ident();
    applyAndCheck("R1 R4 ident d=0", 0, 1'b0, 1'b0);
    applyAndCheck("R1 R4 ident d=1", 1, 1'b0, 1'b0);
    applyAndCheck("R1 R4 ident d=3", 3, 1'b0, 1'b0);
    applyAndCheck("R1 R4 ident d=7", 7, 1'b0, 1'b0);
    applyAndCheck("R1 R4 ident d=100", 100, 1'b0, 1'b0);
  endtask

  task automatic t_data();
    applyAndCheck("R2 data d=0x7FB", 'h7FB, 1'b1, 1'b0);
    applyAndCheck("R2 data d=0x7FF", 'h7FF, 1'b1, 1'b0);
    applyAndCheck("R2 data d=0x008", 'h008, 1'b1, 1'b0);
  endtask

  task automatic t_slow();
    applyAndCheck("R3 slow data d=12", 12, 1'b1, 1'b1);
    applyAndCheck("R3 slow ident d=12", 12, 1'b0, 1'b1);
    applyAndCheck("R3 slow data d=0x40A", 'h40A, 1'b1, 1'b1);
  endtask

  task automatic t_midChange();
    int hi, lo, idx;
    divVal = 11'd5; dataMode = 1'b0; slowCard = 1'b0;
    syncRise();
    hi = 0; lo = 0; idx = 0;
    while (sdClk === 1'b1) begin
      hi++; idx++;
      if (idx == 2) begin divVal = 11'h7F9; dataMode = 1'b1; end
      @(negedge clk);
    end
    while (sdClk === 1'b0) begin lo++; @(negedge clk); end
    chk(hi == 4, "R5 changed period high", hi, 4);
    chk(lo == 3, "R5 changed period low", lo, 3);
    measureFrom(hi, lo);
    chk(hi == 2, "R5 next period high", hi, 2);
    chk(lo == 1, "R5 next period low", lo, 1);
  endtask

  task automatic t_max();
    applyAndCheck("R8 max d=0x7FF", 'h7FF, 1'b0, 1'b0);
    applyAndCheck("R8 back to d=0", 0, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_ident();
    t_data();
    t_slow();
    t_midChange();
    t_max();
    chk(edgeBad == 0, "R7 strobe mismatches", edgeBad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule